// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Port

This block is a word-addressed serial port for a processor bus. Software sets the frame format and the on/off controls in a control word. It then writes characters into a one-deep transmit holding register and collects received characters from a one-deep receive register. A status word reports whether a received character is waiting, whether the last one had a parity mismatch, and whether the transmit holding register is still occupied. Two write-only words empty the transmit and receive registers at once.

Bit timing comes from a one-cycle `tick16` strobe at sixteen times the bit rate. An external baud generator produces that strobe. The port drives the generator's reload value, its mode select and its run enable from its own registers. Frames are 8 data bits sent least significant bit first, with an optional parity bit and one stop bit. The receiver samples each bit in the middle of its sixteen ticks. The interrupt-enable, guard-time and timeout words are plain storage.

Top module: `sio_port`

## Requirements
- R1: The bus reaches words by word index: 0 baud reload (low 16 bits stored), 1 TX data, 2 RX data, 3 control (low 13 bits stored), 4 interrupt enable, 5 status, 6 guard time and 7 timeout (the last three are full 32-bit storage), 8 TX reset, 9 RX reset. Stored words read back what was written, with unstored bits reading 0. `brg_reload` shows the baud word, `brg_fast` shows control bit 12 and `brg_run` shows control bit 7.
- R2: After reset every register and status bit is 0 and `txd` is 1.
- R3: A transmitted frame is one low start bit, then 8 data bits least significant first, then a parity bit only when control[2:0] is 3'b111, then one high stop bit. Each bit lasts 16 ticks, and the line is high while idle. Other mode values, including 3'b001, give 8 bits with no parity.
- R4: With control bit 5 set, the parity bit makes the count of ones in data plus parity odd. With bit 5 clear, it makes that count even.
- R5: Writing word 1 when status bit 9 is 0 stores the character and sets bit 9. Bit 9 clears when the transmitter takes the character. A write to word 1 while bit 9 is 1 is ignored.
- R6: While control bit 7 (run) is 0, no frame is started and a pending character stays pending.
- R7: When run (bit 7) and receive enable (bit 8) are both set, a completed frame is stored and status bit 0 is set. Reading word 2 returns the character in bits [7:0] and clears status bit 0.
- R8: Status bit 2 is set when a received parity bit does not match the parity setting. Reading word 2 clears it.
- R9: A start bit that is high again at its middle sample is rejected and produces no character.
- R10: A frame that completes while status bit 0 is set is dropped, and the stored character is kept.
- R11: Writing word 8 with bit 0 set empties the transmit holding register (bit 9 clears, the character is never sent). Writing word 9 with bit 0 set clears status bits 0 and 2.
- R12: While receive enable is 0, the receiver ignores the line and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle strobe at 16x the bit rate |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe (needed for the RX read side effect) |
| addr | input | 4 | Word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| brg_reload | output | 16 | Reload value for the external baud generator |
| brg_fast | output | 1 | Baud generator mode select |
| brg_run | output | 1 | Baud generator enable |

## Verification
The bench checks the bit order and the parity bit on the wire for both parity senses, including all-zero and all-one data. A swapped sense or a parity bit inserted in the wrong place shows up as a wrong captured frame. It writes back-to-back characters to show that a write while the transmit flag is set is dropped rather than overwriting the pending character. It injects a short low glitch, a wrong parity bit and a second frame before the first is read. A receiver without start validation, parity checking or overrun protection would then report a phantom character, miss the error flag or return the later character. It also shows that the two reset words empty their registers and that disabling run or receive stops traffic.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int MAP_AW = 4;
  localparam int CTRL_W = 13;

  localparam logic [MAP_AW-1:0] A_BAUD  = 4'd0;
  localparam logic [MAP_AW-1:0] A_TXB   = 4'd1;
  localparam logic [MAP_AW-1:0] A_RXB   = 4'd2;
  localparam logic [MAP_AW-1:0] A_CTRL  = 4'd3;
  localparam logic [MAP_AW-1:0] A_IEN   = 4'd4;
  localparam logic [MAP_AW-1:0] A_STAT  = 4'd5;
  localparam logic [MAP_AW-1:0] A_GUARD = 4'd6;
  localparam logic [MAP_AW-1:0] A_TOUT  = 4'd7;
  localparam logic [MAP_AW-1:0] A_TXRST = 4'd8;
  localparam logic [MAP_AW-1:0] A_RXRST = 4'd9;

  localparam int C_ODD  = 5;
  localparam int C_RUN  = 7;
  localparam int C_RXEN = 8;
  localparam int C_FAST = 12;
  localparam logic [2:0] MODE_8P = 3'b111;

  localparam int S_RXF  = 0;
  localparam int S_PERR = 2;
  localparam int S_TXF  = 9;

  // parity bit that completes the requested ones-count sense
  function automatic logic parity_of(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction
endpackage

// File: rtl/sio_tx.sv
module sio_tx #(
  parameter int DATA_W = 8,
  parameter int OS     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              hold_valid,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              take,
  output logic              busy,
  output logic              txd
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int LEN_W   = $clog2(FRAME_W + 1);
  localparam int CNT_W   = $clog2(OS);

  logic [FRAME_W-1:0] sh;
  logic [LEN_W-1:0]   left;
  logic [CNT_W-1:0]   cnt;
  logic               pbit;

  assign pbit = par_en ? sio_pkg::parity_of(hold_data, par_odd) : 1'b1;
  assign take = !busy && run && hold_valid;
  assign txd  = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (!busy) begin
      if (take) begin
        sh   <= {1'b1, pbit, hold_data, 1'b0};
        left <= par_en ? LEN_W'(DATA_W + 3) : LEN_W'(DATA_W + 2);
        cnt  <= '0;
        busy <= 1'b1;
      end
    end else if (tick) begin
      if (cnt == CNT_W'(OS - 1)) begin
        cnt  <= '0;
        sh   <= {1'b1, sh[FRAME_W-1:1]};
        left <= left - 1'b1;
        if (left == LEN_W'(1)) busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sio_rx.sv
module sio_rx #(
  parameter int DATA_W = 8,
  parameter int OS     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              perr,
  output logic              busy
);
  localparam int CNT_W = $clog2(OS);
  localparam int IDX_W = $clog2(DATA_W + 3);
  localparam logic [CNT_W-1:0] MID = CNT_W'(OS / 2 - 1);

  logic [1:0]        sync;
  logic              rxs;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  last_idx;
  logic [DATA_W-1:0] sh;
  logic              prx;
  logic              is_data;

  assign rxs      = sync[1];
  assign last_idx = par_en ? IDX_W'(DATA_W + 2) : IDX_W'(DATA_W + 1);
  assign is_data  = (idx != '0) && (idx <= IDX_W'(DATA_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      idx  <= '0;
      sh   <= '0;
      prx  <= 1'b0;
      done <= 1'b0;
      data <= '0;
      perr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!enable) begin
        busy <= 1'b0;
      end else if (!busy) begin
        if (!rxs) begin
          busy <= 1'b1;
          cnt  <= '0;
          idx  <= '0;
        end
      end else if (tick) begin
        cnt <= (cnt == CNT_W'(OS - 1)) ? '0 : cnt + 1'b1;
        if (cnt == MID) begin
          idx <= idx + 1'b1;
          if (idx == '0) begin
            if (rxs) busy <= 1'b0;          // glitch, not a start bit
          end else if (is_data) begin
            sh <= {rxs, sh[DATA_W-1:1]};
          end else if (idx == last_idx) begin
            busy <= 1'b0;
            done <= 1'b1;
            data <= sh;
            perr <= par_en && (prx != sio_pkg::parity_of(sh, par_odd));
          end else begin
            prx <= rxs;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sio_port.sv
module sio_port #(
  parameter int DATA_W = 8,
  parameter int OS     = 16,
  parameter int BAUD_W = 16,
  parameter int WORD_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick16,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [sio_pkg::MAP_AW-1:0] addr,
  input  logic [WORD_W-1:0]         wdata,
  output logic [WORD_W-1:0]         rdata,
  output logic                      txd,
  input  logic                      rxd,
  output logic [BAUD_W-1:0]         brg_reload,
  output logic                      brg_fast,
  output logic                      brg_run
);
  import sio_pkg::*;

  logic [BAUD_W-1:0] baud_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [WORD_W-1:0] ien_q, guard_q, tout_q;

  logic              tx_hold_valid;
  logic [DATA_W-1:0] tx_hold_data;
  logic              rx_full, rx_perr;
  logic [DATA_W-1:0] rx_buf;

  // named events for the checker
  logic wr_txb, rd_rx, txrst_wr, rxrst_wr;
  logic run, rx_en, par_en, par_odd;
  logic tx_take, tx_busy;
  logic rx_done, rx_busy, rx_perr_in;
  logic [DATA_W-1:0] rx_data;

  assign wr_txb   = wr_en && addr == A_TXB;
  assign rd_rx    = rd_en && addr == A_RXB;
  assign txrst_wr = wr_en && addr == A_TXRST && wdata[0];
  assign rxrst_wr = wr_en && addr == A_RXRST && wdata[0];
  assign run      = ctrl_q[C_RUN];
  assign rx_en    = ctrl_q[C_RUN] && ctrl_q[C_RXEN];
  assign par_en   = ctrl_q[2:0] == MODE_8P;
  assign par_odd  = ctrl_q[C_ODD];

  assign brg_reload = baud_q;
  assign brg_fast   = ctrl_q[C_FAST];
  assign brg_run    = ctrl_q[C_RUN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baud_q  <= '0;
      ctrl_q  <= '0;
      ien_q   <= '0;
      guard_q <= '0;
      tout_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        A_BAUD:  baud_q  <= wdata[BAUD_W-1:0];
        A_CTRL:  ctrl_q  <= wdata[CTRL_W-1:0];
        A_IEN:   ien_q   <= wdata;
        A_GUARD: guard_q <= wdata;
        A_TOUT:  tout_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hold_valid <= 1'b0;
      tx_hold_data  <= '0;
    end else if (txrst_wr) begin
      tx_hold_valid <= 1'b0;
    end else if (wr_txb && !tx_hold_valid) begin
      tx_hold_valid <= 1'b1;
      tx_hold_data  <= wdata[DATA_W-1:0];
    end else if (tx_take) begin
      tx_hold_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rx_perr <= 1'b0;
      rx_buf  <= '0;
    end else if (rxrst_wr) begin
      rx_full <= 1'b0;
      rx_perr <= 1'b0;
    end else if (rx_done && !rx_full) begin
      rx_full <= 1'b1;
      rx_buf  <= rx_data;
      rx_perr <= rx_perr_in;
    end else if (rd_rx) begin
      rx_full <= 1'b0;
      rx_perr <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_BAUD:  rdata[BAUD_W-1:0] = baud_q;
      A_RXB:   rdata[DATA_W-1:0] = rx_buf;
      A_CTRL:  rdata[CTRL_W-1:0] = ctrl_q;
      A_IEN:   rdata = ien_q;
      A_GUARD: rdata = guard_q;
      A_TOUT:  rdata = tout_q;
      A_STAT: begin
        rdata[S_RXF]  = rx_full;
        rdata[S_PERR] = rx_perr;
        rdata[S_TXF]  = tx_hold_valid;
      end
      default: ;
    endcase
  end

  sio_tx #(.DATA_W(DATA_W), .OS(OS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .run(run),
    .hold_valid(tx_hold_valid), .hold_data(tx_hold_data),
    .par_en(par_en), .par_odd(par_odd),
    .take(tx_take), .busy(tx_busy), .txd(txd)
  );

  sio_rx #(.DATA_W(DATA_W), .OS(OS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .enable(rx_en), .rxd(rxd),
    .par_en(par_en), .par_odd(par_odd),
    .done(rx_done), .data(rx_data), .perr(rx_perr_in), .busy(rx_busy)
  );
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txd,
  input logic              tx_busy,
  input logic              tx_take,
  input logic              tx_hold_valid,
  input logic [DATA_W-1:0] tx_hold_data,
  input logic              wr_txb,
  input logic              txrst_wr,
  input logic              run,
  input logic              rx_en,
  input logic              rx_busy,
  input logic              rx_done,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_full,
  input logic [DATA_W-1:0] rx_buf,
  input logic              rd_rx,
  input logic              rxrst_wr
);
  assert_idle_line_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  assert_full_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txb && tx_hold_valid && !txrst_wr && !tx_take) |=>
      (tx_hold_valid && $stable(tx_hold_data)));

  assert_no_start_when_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !tx_busy) |=> !tx_busy);

  assert_rx_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_full && !rxrst_wr) |=> (rx_full && rx_buf == $past(rx_data)));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && rx_full && !rxrst_wr) |=> !rx_full);

  assert_overrun_keeps_old_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_full && !rd_rx && !rxrst_wr) |=> (rx_full && $stable(rx_buf)));

  assert_rx_reset_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rxrst_wr |=> !rx_full);

  assert_rx_off_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_busy);
endmodule

bind sio_port sio_port_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy), .tx_take(tx_take),
  .tx_hold_valid(tx_hold_valid), .tx_hold_data(tx_hold_data), .wr_txb(wr_txb),
  .txrst_wr(txrst_wr), .run(run), .rx_en(rx_en), .rx_busy(rx_busy),
  .rx_done(rx_done), .rx_data(rx_data), .rx_full(rx_full), .rx_buf(rx_buf),
  .rd_rx(rd_rx), .rxrst_wr(rxrst_wr)
);

// File: tb/test_sio_port.sv
module test_sio_port;
  localparam int BIT_CLK = 64;   // 16 ticks x 4 clocks
  localparam logic [31:0] C_RUN  = 32'h0080;
  localparam logic [31:0] C_RXEN = 32'h0100;
  localparam logic [31:0] C_ODD  = 32'h0020;
  localparam logic [31:0] C_STOP1 = 32'h0008;

  typedef struct packed { logic [7:0] d; logic pe; logic odd; } vec_t;
  localparam vec_t VECS [6] = '{
    '{8'h55, 1'b0, 1'b0}, '{8'hA3, 1'b1, 1'b0}, '{8'hA3, 1'b1, 1'b1},
    '{8'h00, 1'b1, 1'b1}, '{8'hFF, 1'b1, 1'b0}, '{8'h80, 1'b0, 1'b1}};

  logic clk = 0, rst_n = 0, tick16 = 0;
  logic wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic txd, rxd, rxd_drv = 1, use_loop = 1;
  logic [15:0] brg_reload;
  logic brg_fast, brg_run;
  int checks = 0, errors = 0;
  logic [1:0] tdiv = 0;

  always #10 clk = ~clk;
  always @(posedge clk) begin
    tdiv   <= tdiv + 1'b1;
    tick16 <= (tdiv == 2'd3);
  end
  assign rxd = use_loop ? txd : rxd_drv;

  sio_port i_sio_port (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd),
    .brg_reload(brg_reload), .brg_fast(brg_fast), .brg_run(brg_run));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_rx(output bit got);
    logic [31:0] s;
    got = 0;
    for (int i = 0; i < 1500 && !got; i++) begin
      peek(4'd5, s);
      got = s[0];
    end
  endtask

  function automatic logic exp_par(input logic [7:0] d, input logic odd);
    return (($countones(d) % 2) == 0) ? odd : !odd;
  endfunction

  task automatic drive_frame(input logic [7:0] d, input bit has_par, input logic pb);
    @(negedge clk); rxd_drv = 0; repeat (BIT_CLK) @(negedge clk);
    for (int k = 0; k < 8; k++) begin rxd_drv = d[k]; repeat (BIT_CLK) @(negedge clk); end
    if (has_par) begin rxd_drv = pb; repeat (BIT_CLK) @(negedge clk); end
    rxd_drv = 1; repeat (BIT_CLK) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [10:0] cap, exp_f;
    bit got, fell;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2: reset state
    peek(4'd5, r);  check(r == 0, "R2 status", r, 0);
    peek(4'd3, r);  check(r == 0, "R2 control", r, 0);
    check(txd == 1'b1, "R2 txd", {31'd0, txd}, 1);

    // R1: storage and readback
    bus_write(4'd0, 32'h1234_ABCD);
    peek(4'd0, r);  check(r == 32'h0000_ABCD, "R1 baud", r, 32'h0000_ABCD);
    check(brg_reload == 16'hABCD, "R1 brg_reload", {16'd0, brg_reload}, 32'hABCD);
    bus_write(4'd3, 32'hFFFF_F0A9);
    peek(4'd3, r);  check(r == 32'h10A9, "R1 control", r, 32'h10A9);
    check(brg_fast && brg_run, "R1 brg mode/run", {30'd0, brg_fast, brg_run}, 3);
    bus_write(4'd4, 32'hDEAD_0001); bus_write(4'd6, 32'h0BAD_F00D); bus_write(4'd7, 32'h8000_0007);
    peek(4'd4, r);  check(r == 32'hDEAD_0001, "R1 inten", r, 32'hDEAD_0001);
    peek(4'd6, r);  check(r == 32'h0BAD_F00D, "R1 guard", r, 32'h0BAD_F00D);
    peek(4'd7, r);  check(r == 32'h8000_0007, "R1 timeout", r, 32'h8000_0007);
    bus_write(4'd3, 32'h0);

    // R3 R4 R7: loopback vector table
    foreach (VECS[i]) begin
      bus_write(4'd3, C_RUN | C_RXEN | C_STOP1 | (VECS[i].pe ? 32'h7 : 32'h1) |
                      (VECS[i].odd ? C_ODD : 32'h0));
      bus_write(4'd1, {24'd0, VECS[i].d});
      fell = 0;
      for (int t = 0; t < 2000 && !fell; t++) begin @(negedge clk); fell = !txd; end
      cap = '1;
      repeat (BIT_CLK / 2) @(negedge clk);
      for (int k = 0; k < (VECS[i].pe ? 11 : 10); k++) begin
        cap[k] = txd;
        repeat (BIT_CLK) @(negedge clk);
      end
      exp_f = VECS[i].pe ? {1'b1, exp_par(VECS[i].d, VECS[i].odd), VECS[i].d, 1'b0}
                         : {2'b11, VECS[i].d, 1'b0};
      check(cap == exp_f, "R3/R4 wire frame", {21'd0, cap}, {21'd0, exp_f});
      wait_rx(got);
      bus_read(4'd2, r);
      check(got && r == {24'd0, VECS[i].d}, "R7 rx data", r, {24'd0, VECS[i].d});
      peek(4'd5, r);  check(r == 0, "R7 status after read", r, 0);
    end

    // R5: back-to-back writes, third dropped
    bus_write(4'd3, C_RUN | C_RXEN | 32'h1);
    bus_write(4'd1, 32'h41);
    bus_write(4'd1, 32'h42);
    peek(4'd5, r);  check(r[9] == 1'b1, "R5 tx full set", r, 32'h200);
    bus_write(4'd1, 32'h43);
    wait_rx(got); bus_read(4'd2, r);
    check(got && r == 32'h41, "R5 first char", r, 32'h41);
    wait_rx(got); bus_read(4'd2, r);
    check(got && r == 32'h42, "R5 pending char kept", r, 32'h42);
    repeat (1000) @(negedge clk);
    peek(4'd5, r);  check(r == 0, "R5 ignored write not sent", r, 0);

    // R6 and R11 (TX reset)
    bus_write(4'd3, C_RXEN | 32'h1);
    bus_write(4'd1, 32'h5A);
    fell = 0;
    for (int t = 0; t < 800; t++) begin @(negedge clk); if (!txd) fell = 1; end
    check(!fell, "R6 no frame while stopped", {31'd0, fell}, 0);
    peek(4'd5, r);  check(r[9] == 1'b1, "R6 char stays pending", r, 32'h200);
    bus_write(4'd8, 32'h1);
    peek(4'd5, r);  check(r[9] == 1'b0, "R11 tx reset clears full", r, 0);
    bus_write(4'd3, C_RUN | C_RXEN | 32'h1);
    repeat (900) @(negedge clk);
    peek(4'd5, r);  check(r == 0, "R11 reset char never sent", r, 0);

    // R11: RX reset
    bus_write(4'd1, 32'h99);
    wait_rx(got);
    bus_write(4'd9, 32'h1);
    peek(4'd5, r);  check(got && r == 0, "R11 rx reset clears full", r, 0);

    // R8: injected parity error (even parity of 0F is 0, send 1)
    use_loop = 0;
    bus_write(4'd3, C_RUN | C_RXEN | 32'h7);
    drive_frame(8'h0F, 1, 1'b1);
    wait_rx(got);
    peek(4'd5, r);  check(got && r[2], "R8 parity error flag", r, 32'h5);
    bus_read(4'd2, r); check(r == 32'h0F, "R8 data kept", r, 32'h0F);
    peek(4'd5, r);  check(r == 0, "R8 read clears error", r, 0);

    // R9: glitch rejected, real frame follows
    bus_write(4'd3, C_RUN | C_RXEN | 32'h1);
    @(negedge clk); rxd_drv = 0; repeat (16) @(negedge clk); rxd_drv = 1;
    repeat (1000) @(negedge clk);
    peek(4'd5, r);  check(r == 0, "R9 glitch rejected", r, 0);
    drive_frame(8'h3C, 0, 1'b0);
    wait_rx(got); bus_read(4'd2, r);
    check(got && r == 32'h3C, "R9 frame after glitch", r, 32'h3C);

    // R10: overrun keeps first
    drive_frame(8'h11, 0, 1'b0);
    drive_frame(8'h22, 0, 1'b0);
    repeat (50) @(negedge clk);
    bus_read(4'd2, r); check(r == 32'h11, "R10 first char kept", r, 32'h11);
    peek(4'd5, r);  check(r == 0, "R10 second dropped", r, 0);

    // R12: receiver disabled
    bus_write(4'd3, C_RUN | 32'h1);
    drive_frame(8'h77, 0, 1'b0);
    repeat (50) @(negedge clk);
    peek(4'd5, r);  check(r == 0, "R12 rx disabled", r, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule